// File: doc/BRIEF.md
# Coadded Frame FIFO Unloader

This block drains accumulated 32-bit pixel sums out of a frame memory and pushes them into a 16-bit wide output FIFO. Every pixel becomes two FIFO words, the upper half first. Pixels are grouped into fixed-size bursts. Before each burst the block waits until the FIFO is no longer half full. Once a burst has begun, all of its words are written without checking that flag again.

The frame memory is addressed as {region, page, pixel}. A frame is made of two pages, and the memory holds two regions: a reset region and an exposure region. A single pulse on the start input clears the FIFO and then sends the whole image in address order. When the double-sampling flag is sampled high at start, the reset region is sent and then the exposure region. When it is low, only the exposure region is sent. A one-cycle done pulse closes the transfer. The memory read port has a fixed, parameterised latency. The block waits out that latency for every pixel, so no pixel is lost or repeated.

Top module: `fifo_unloader`

## Requirements
- R1: Each pixel is written as two consecutive FIFO words: bits PIX_W-1:HALF_W in the first cycle, then bits HALF_W-1:0 in the very next cycle.
- R2: Within a page, pixels are read from the memory in ascending order of the low PAGE_AW address bits, starting at 0 and ending at BURST_LEN*BURSTS_PER_PAGE-1.
- R3: Every region is sent as page 0 and then page 1, where the page is address bit PAGE_AW.
- R4: With cds_i high at start, region 0 (address bit PAGE_AW+1 = 0) is sent before region 1. With cds_i low, only region 1 is sent.
- R5: Before the first read of every burst of BURST_LEN pixels, the block waits while fifo_hf_i is high. While fifo_hf_i stays high it issues no read and no write. Inside a burst, fifo_hf_i has no effect.
- R6: After an accepted start, fifo_clr_o pulses for exactly one cycle, before any FIFO write of that transfer.
- R7: Data is taken RD_LAT cycles after its read strobe. Each read yields exactly one word pair, with no duplicated or skipped pixel, and at most one read is outstanding.
- R8: done_o pulses for one cycle, in the cycle after the low half of the last pixel is written. A start pulse during a transfer is ignored.
- R9: After reset, all strobes are low and the address and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| cds_i | input | 1 | Send both regions when high, sampled at start |
| mem_rd_o | output | 1 | Frame memory read strobe |
| mem_addr_o | output | ADDR_W | Frame memory address {region, page, pixel} |
| mem_data_i | input | PIX_W | Read data, valid RD_LAT cycles after the strobe |
| fifo_clr_o | output | 1 | Output FIFO clear pulse |
| fifo_we_o | output | 1 | Output FIFO write strobe |
| fifo_data_o | output | HALF_W | Output FIFO write data |
| fifo_hf_i | input | 1 | Output FIFO half-full flag |
| done_o | output | 1 | Transfer complete pulse |

## Verification
The bench builds the block with BURST_LEN=4, BURSTS_PER_PAGE=2 and RD_LAT=2. A page is then only eight pixels and a full two-region image is 32 pixels. Every burst boundary, page crossing and region crossing therefore occurs many times per run. The two-cycle read latency exercises the deep branch of the read-latency pipeline.

// File: rtl/fu_pkg.sv
package fu_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLR,
      ST_GATE,
      ST_READ,
      ST_WAIT,
      ST_HI,
      ST_LO,
      ST_DONE
   } fu_state_e;
endpackage

// File: rtl/fu_addr_seq.sv
module fu_addr_seq #(
   parameter int PAGE_AW   = 16,
   parameter int BURST_LEN = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               cds_i,
   input  logic               step_i,
   output logic [PAGE_AW+1:0] addr_o,
   output logic               burst_end_o,
   output logic               last_o
);
   localparam int BURST_AW = $clog2(BURST_LEN);

   logic [PAGE_AW-1:0] pix_q;
   logic               page_q;
   logic               region_q;
   logic               pix_wrap;

   assign pix_wrap = &pix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q    <= '0;
         page_q   <= 1'b0;
         region_q <= 1'b0;
      end else if (load_i) begin
         pix_q    <= '0;
         page_q   <= 1'b0;
         region_q <= ~cds_i;
      end else if (step_i) begin
         if (pix_wrap) begin
            pix_q <= '0;
            if (page_q) begin
               page_q   <= 1'b0;
               region_q <= 1'b1;
            end else begin
               page_q <= 1'b1;
            end
         end else begin
            pix_q <= pix_q + 1'b1;
         end
      end
   end

   assign addr_o      = {region_q, page_q, pix_q};
   assign burst_end_o = &pix_q[BURST_AW-1:0];
   assign last_o      = region_q & page_q & pix_wrap;
endmodule

// File: rtl/fu_rd_pipe.sv
module fu_rd_pipe #(
   parameter int LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_i,
   output logic vld_o
);
   generate
      if (LAT == 1) begin : g_single
         logic v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q <= 1'b0;
            else        v_q <= rd_i;
         end
         assign vld_o = v_q;
      end else begin : g_chain
         logic [LAT-1:0] v_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q <= '0;
            else        v_q <= {v_q[LAT-2:0], rd_i};
         end
         assign vld_o = v_q[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/fifo_unloader.sv
module fifo_unloader
   import fu_pkg::*;
#(
   parameter int PIX_W           = 32,
   parameter int BURST_LEN       = 64,
   parameter int BURSTS_PER_PAGE = 1024,
   parameter int RD_LAT          = 1,
   localparam int HALF_W  = PIX_W / 2,
   localparam int PAGE_AW = $clog2(BURST_LEN * BURSTS_PER_PAGE),
   localparam int ADDR_W  = PAGE_AW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cds_i,
   output logic              mem_rd_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [PIX_W-1:0]  mem_data_i,
   output logic              fifo_clr_o,
   output logic              fifo_we_o,
   output logic [HALF_W-1:0] fifo_data_o,
   input  logic              fifo_hf_i,
   output logic              done_o
);
   generate
      if (PIX_W % 2 != 0) begin : g_bad_width
         $error("PIX_W must be even");
      end
      if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
         $error("BURST_LEN must be a power of two of at least 2");
      end
      if (BURSTS_PER_PAGE < 1 || (BURSTS_PER_PAGE & (BURSTS_PER_PAGE - 1)) != 0) begin : g_bad_bpp
         $error("BURSTS_PER_PAGE must be a power of two");
      end
      if (RD_LAT < 1) begin : g_bad_lat
         $error("RD_LAT must be at least 1");
      end
   endgenerate

   fu_state_e        state_q, state_d;
   logic [PIX_W-1:0] hold_q;
   logic             load, step, data_vld;
   logic             burst_end, last;

   fu_addr_seq #(
      .PAGE_AW   (PAGE_AW),
      .BURST_LEN (BURST_LEN)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load),
      .cds_i       (cds_i),
      .step_i      (step),
      .addr_o      (mem_addr_o),
      .burst_end_o (burst_end),
      .last_o      (last)
   );

   fu_rd_pipe #(
      .LAT (RD_LAT)
   ) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_i  (mem_rd_o),
      .vld_o (data_vld)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_i)    state_d = ST_CLR;
         ST_CLR:                  state_d = ST_GATE;
         ST_GATE: if (!fifo_hf_i) state_d = ST_READ;
         ST_READ:                 state_d = ST_WAIT;
         ST_WAIT: if (data_vld)   state_d = ST_HI;
         ST_HI:                   state_d = ST_LO;
         ST_LO: begin
            if (last)           state_d = ST_DONE;
            else if (burst_end) state_d = ST_GATE;
            else                state_d = ST_READ;
         end
         ST_DONE:                 state_d = ST_IDLE;
         default:                 state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_WAIT && data_vld) hold_q <= mem_data_i;
      end
   end

   assign load        = (state_q == ST_IDLE) && start_i;
   assign step        = (state_q == ST_LO);
   assign mem_rd_o    = (state_q == ST_READ);
   assign fifo_clr_o  = (state_q == ST_CLR);
   assign fifo_we_o   = (state_q == ST_HI) || (state_q == ST_LO);
   assign fifo_data_o = (state_q == ST_HI) ? hold_q[PIX_W-1:HALF_W] : hold_q[HALF_W-1:0];
   assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/fu_checker.sv
module fu_checker #(
   parameter int BURST_LEN = 64
) (
   input logic clk,
   input logic rst_n,
   input logic mem_rd_o,
   input logic fifo_clr_o,
   input logic fifo_we_o,
   input logic fifo_hf_i,
   input logic done_o
);
   localparam int CW = $clog2(BURST_LEN);

   logic [CW-1:0] rd_cnt;
   logic          wpar;
   logic          active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_cnt <= '0;
         wpar   <= 1'b0;
         active <= 1'b0;
      end else begin
         if (fifo_clr_o)    rd_cnt <= '0;
         else if (mem_rd_o) rd_cnt <= rd_cnt + 1'b1;
         if (fifo_clr_o)     wpar <= 1'b0;
         else if (fifo_we_o) wpar <= ~wpar;
         if (fifo_clr_o)  active <= 1'b1;
         else if (done_o) active <= 1'b0;
      end
   end

   assert_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_we_o && !wpar) |=> fifo_we_o);

   assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_o && rd_cnt == '0) |-> !$past(fifo_hf_i));

   assert_clr_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_we_o |-> active);

   assert_clr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr_o |=> !fifo_clr_o);

   assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_o |=> !mem_rd_o);

   assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd_o, fifo_we_o, fifo_clr_o, done_o}));

   assert_done_after_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(fifo_we_o) && !wpar));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
endmodule

bind fifo_unloader fu_checker #(
   .BURST_LEN (BURST_LEN)
) u_fu_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_rd_o   (mem_rd_o),
   .fifo_clr_o (fifo_clr_o),
   .fifo_we_o  (fifo_we_o),
   .fifo_hf_i  (fifo_hf_i),
   .done_o     (done_o)
);

// File: tb/tb_fifo_unloader.sv
`timescale 1ns/1ps
module tb_fifo_unloader;
   localparam int BL      = 4;
   localparam int BPP     = 2;
   localparam int LAT     = 2;
   localparam int PAGE_AW = $clog2(BL * BPP);
   localparam int AW      = PAGE_AW + 2;
   localparam int PAGE_PX = BL * BPP;
   localparam int REG_PX  = 2 * PAGE_PX;
   localparam int MEM_N   = 4 * PAGE_PX;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          cds_i = 1'b0;
   logic          mem_rd_o;
   logic [AW-1:0] mem_addr_o;
   logic [31:0]   mem_data_i;
   logic          fifo_clr_o, fifo_we_o, done_o;
   logic [15:0]   fifo_data_o;
   logic          fifo_hf_i = 1'b0;

   always #10 clk = ~clk;

   fifo_unloader #(
      .PIX_W(32), .BURST_LEN(BL), .BURSTS_PER_PAGE(BPP), .RD_LAT(LAT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .cds_i(cds_i),
      .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
      .fifo_clr_o(fifo_clr_o), .fifo_we_o(fifo_we_o), .fifo_data_o(fifo_data_o),
      .fifo_hf_i(fifo_hf_i), .done_o(done_o)
   );

   // memory model with LAT-cycle read latency
   logic [31:0] mem [MEM_N];
   logic [31:0] pipe [LAT];
   always_ff @(posedge clk) begin
      pipe[0] <= mem_rd_o ? mem[mem_addr_o] : 32'hDEAD_BEEF;
      for (int k = 1; k < LAT; k++) pipe[k] <= pipe[k-1];
   end
   assign mem_data_i = pipe[LAT-1];

   int errs = 0, checks = 0;
   int cyc = 0;
   int hf_mode = 0;          // 0 low, 1 random, 2 held high
   int nw, nr, nclr, ndone, clr_late, gate_viol, rd_in_hold, we_in_hf;
   int last_we_cyc, done_cyc;
   logic [15:0]   wbuf [64];
   logic [AW-1:0] rbuf [32];

   // monitor and flag driver, away from the active edge
   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errs++;
         $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks + 1);
         $finish;
      end
      if (fifo_we_o) begin
         if (nw < 64) wbuf[nw] = fifo_data_o;
         if (fifo_hf_i) we_in_hf++;
         nw++;
         last_we_cyc = cyc;
      end
      if (mem_rd_o) begin
         if (nr < 32) rbuf[nr] = mem_addr_o;
         if ((nr % BL) == 0 && fifo_hf_i) gate_viol++;
         if (hf_mode == 2) rd_in_hold++;
         nr++;
      end
      if (fifo_clr_o) begin
         nclr++;
         if (nw > 0) clr_late++;
      end
      if (done_o) begin
         ndone++;
         done_cyc = cyc;
      end
      case (hf_mode)
         1:       fifo_hf_i = (($urandom % 3) == 0);
         2:       fifo_hf_i = 1'b1;
         default: fifo_hf_i = 1'b0;
      endcase
   end

   function automatic logic [AW-1:0] exp_addr(input int idx, input logic cds);
      return AW'((cds ? 0 : REG_PX) + idx);
   endfunction

   function automatic logic [15:0] exp_word(input int w, input logic cds);
      logic [31:0] px;
      px = mem[exp_addr(w / 2, cds)];
      return (w % 2 == 0) ? px[31:16] : px[15:0];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run(input logic cds, input int mode, input int hold_cyc, input bit restart);
      int npx, bad_a, bad_w, first_bad;
      @(posedge clk); #1;
      for (int i = 0; i < MEM_N; i++) mem[i] = $urandom;
      nw = 0; nr = 0; nclr = 0; ndone = 0; clr_late = 0; gate_viol = 0;
      rd_in_hold = 0; we_in_hf = 0; last_we_cyc = -1; done_cyc = -1;
      hf_mode = (hold_cyc > 0) ? 2 : mode;
      @(negedge clk); cds_i = cds; start_i = 1'b1;
      @(negedge clk); start_i = 1'b0; cds_i = $urandom;
      if (hold_cyc > 0) begin
         repeat (hold_cyc) @(negedge clk);
         check(nw == 0 && rd_in_hold == 0, "R5 held flag blocks", nw + rd_in_hold, 0);
         @(posedge clk); #1; hf_mode = mode;
      end
      if (restart) begin
         repeat (15) @(negedge clk);
         start_i = 1'b1;
         @(negedge clk); start_i = 1'b0;
      end
      for (int t = 0; t < 5000 && ndone == 0; t++) @(negedge clk);
      repeat (4) @(negedge clk);
      check(ndone == 1, "R8 done count", ndone, 1);
      @(posedge clk); #1; hf_mode = 0;
      npx = cds ? 2 * REG_PX : REG_PX;
      bad_a = 0; bad_w = 0; first_bad = -1;
      for (int i = 0; i < npx && i < nr && i < 32; i++)
         if (rbuf[i] !== exp_addr(i, cds)) begin
            if (first_bad < 0) first_bad = i;
            bad_a++;
         end
      check(nr == npx && bad_a == 0, "R2/R3/R4 address order",
            (bad_a != 0) ? int'(rbuf[first_bad]) : nr,
            (bad_a != 0) ? int'(exp_addr(first_bad, cds)) : npx);
      first_bad = -1;
      for (int i = 0; i < 2 * npx && i < nw && i < 64; i++)
         if (wbuf[i] !== exp_word(i, cds)) begin
            if (first_bad < 0) first_bad = i;
            bad_w++;
         end
      check(nw == 2 * npx && bad_w == 0, "R1/R7 word stream",
            (bad_w != 0) ? int'(wbuf[first_bad]) : nw,
            (bad_w != 0) ? int'(exp_word(first_bad, cds)) : 2 * npx);
      check(nclr == 1 && clr_late == 0, "R6 single clear before writes", nclr, 1);
      check(done_cyc == last_we_cyc + 1, "R8 done after last low half", done_cyc, last_we_cyc + 1);
      check(gate_viol == 0, "R5 burst gate", gate_viol, 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check(!mem_rd_o && !fifo_we_o && !fifo_clr_o && !done_o, "R9 reset strobes",
            {mem_rd_o, fifo_we_o, fifo_clr_o, done_o}, 0);
      check(mem_addr_o == '0 && fifo_data_o == '0, "R9 reset data",
            int'(mem_addr_o) + int'(fifo_data_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // directed: R4 exposure only, then both regions
      run(1'b0, 0, 0, 1'b0);
      run(1'b1, 0, 0, 1'b0);
      // R5: flag held high at start, then released
      run(1'b1, 0, 40, 1'b0);
      // R8: start during a transfer is ignored
      run(1'b0, 0, 0, 1'b1);
      // random flag traffic, random region selection
      we_in_hf = 0;
      begin
         int hf_writes = 0;
         for (int r = 0; r < 6; r++) begin
            run(logic'($urandom % 2), 1, 0, 1'b0);
            hf_writes += we_in_hf;
         end
         check(hf_writes > 0, "R5 flag ignored inside burst", hf_writes, 1);
      end
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule